// File: doc/BRIEF.md
# Serial LED Shift-Out Engine

This block drives an external chain of serial-in, parallel-out shift registers that fan out LED or GPIO outputs. It turns a 17-bit pin vector into a frame on two wires: a shift clock and a data line. The bit rate comes from a 2-bit divider select. A programmable delay sets how long the data line waits after the clock falls before it moves to the next bit.

There are two ways to launch a frame. In direct mode, software writes the data field over a small register port, and every such write sends one frame, even an all-zero one, so the chain can be cleared on purpose. In PWM-driven mode, the engine watches the pin vector from the waveform generators. It sends a frame only when that vector differs from the last one it shifted. After reset the last frame counts as all-zero, so nothing is shifted until some pin must go high. While a frame is on the wire, a busy flag in the data register is set. During that time the engine ignores data writes, configuration writes and any attempt to enable PWM mode. Clearing PWM mode stops the engine at once.

Top module: `sled_shift_engine`

## Requirements
- R1: After reset, ser_clk and ser_data are 0, busy is 0, and every register reads back as zero.
- R2: A bit slot lasts N = 4 << div clock cycles, where div is the divider field (0 gives 4, 1 gives 8, 2 gives 16, 3 gives 32). ser_clk is low for the first N/2 cycles of a slot and high for the last N/2. ser_clk is low whenever the engine is idle.
- R3: Within slot b, ser_data shows bit b from phase D onward and still shows bit b-1 before phase D. D is the delay field clamped to N/2-1, so D = 0 is allowed. ser_data never changes while ser_clk is high.
- R4: A frame is 17 slots long, and busy stays high for exactly 17*N cycles. Mode bit 0 sets the bit order: 0 sends bit 16 first, 1 sends bit 0 first.
- R5: A data write (register select 0) while idle launches a frame of that value, including the value zero. Busy reads 1 from the cycle after the write.
- R6: While busy, writes to the data, divider and delay registers are ignored. A mode write cannot change the order bit and cannot set the PWM bit. A mode write that clears the PWM bit (bit 1) aborts the frame, so busy and ser_clk are 0 on the next cycle.
- R7: In PWM mode, an idle engine launches a frame of pin_vec when pin_vec differs from the last shifted frame. When the two are equal, including all-zero pins after reset, nothing is shifted.
- R8: The read port decodes rd_sel as follows: 0 gives the last shifted frame in bits 16:0 and busy in bit 31; 1 gives the divider in bits 1:0; 2 gives the delay in bits 3:0; 3 gives the mode, with the order bit in bit 0 and the PWM bit in bit 1. All other bits read as 0.
- R9: While idle, and after an abort, ser_data holds the last bit that completed a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_vec | input | 17 | Pin values from the generator bank |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select (0 data, 1 divider, 2 delay, 3 mode) |
| wr_data | input | 17 | Write value; low bits are used for the narrow registers |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 32 | Read value for rd_sel |
| ser_clk | output | 1 | Shift clock to the external chain |
| ser_data | output | 1 | Serial data to the external chain |

## Verification
The assertions check the following on every cycle:
- ser_clk stays low while idle.
- ser_data holds steady while ser_clk is high, and the effective delay stays within its limit.
- The busy flag blocks data writes and PWM enabling.
- A data write while idle raises busy.
- A PWM-mode engine with unchanged pins stays idle.

The bench scenarios cover what cannot be checked cycle by cycle:
- The exact waveform of each bit slot for every divider, every delay and both bit orders.
- Frames launched by pin changes during a running frame.
- An aborted frame.
- The read-back of ignored writes.

// File: rtl/sled_pkg.sv
package sled_pkg;
    localparam int unsigned RD_W = 32;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIV  = 2'd1,
        SEL_DLY  = 2'd2,
        SEL_MODE = 2'd3
    } sled_sel_e;
endpackage

// File: rtl/sled_cfg.sv
module sled_cfg #(
    parameter int unsigned NBITS = 17,
    parameter int unsigned DIV_W = 2,
    parameter int unsigned DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [NBITS-1:0] wr_data,
    input  logic [NBITS-1:0] pin_vec,
    input  logic             busy,
    output logic [DIV_W-1:0] div_sel,
    output logic [DLY_W-1:0] dly_raw,
    output logic             lsb_first,
    output logic             pwm_en,
    output logic [NBITS-1:0] last_vec,
    output logic             launch,
    output logic [NBITS-1:0] launch_vec,
    output logic             launch_lsb,
    output logic             abort
);
    import sled_pkg::*;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [DLY_W-1:0] dly;
        logic             lsb;
        logic             pwm;
        logic [NBITS-1:0] last;
    } cfg_t;

    cfg_t st_d, st_q;
    logic launch_d, abort_d;
    logic [NBITS-1:0] vec_d;

    always_comb begin
        st_d     = st_q;
        launch_d = 1'b0;
        abort_d  = 1'b0;
        vec_d    = st_q.last;
        if (wr_en) begin
            case (sled_sel_e'(wr_sel))
                SEL_DATA: if (!busy) begin
                    st_d.last = wr_data;
                    vec_d     = wr_data;
                    launch_d  = 1'b1;
                end
                SEL_DIV:  if (!busy) st_d.div = wr_data[DIV_W-1:0];
                SEL_DLY:  if (!busy) st_d.dly = wr_data[DLY_W-1:0];
                SEL_MODE: begin
                    if (busy) begin
                        if (st_q.pwm && !wr_data[1]) begin
                            st_d.pwm = 1'b0;
                            abort_d  = 1'b1;
                        end
                    end else begin
                        st_d.lsb = wr_data[0];
                        st_d.pwm = wr_data[1];
                    end
                end
                default: ;
            endcase
        end
        if (!launch_d && !busy && st_q.pwm && st_d.pwm && (pin_vec != st_q.last)) begin
            launch_d  = 1'b1;
            vec_d     = pin_vec;
            st_d.last = pin_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign div_sel    = st_q.div;
    assign dly_raw    = st_q.dly;
    assign lsb_first  = st_q.lsb;
    assign pwm_en     = st_q.pwm;
    assign last_vec   = st_q.last;
    assign launch     = launch_d;
    assign launch_vec = vec_d;
    assign launch_lsb = st_d.lsb;
    assign abort      = abort_d;
endmodule

// File: rtl/sled_serializer.sv
module sled_serializer #(
    parameter int unsigned NBITS = 17,
    parameter int unsigned DIV_W = 2,
    parameter int unsigned PH_W  = 5,
    parameter int unsigned DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [NBITS-1:0] launch_vec,
    input  logic             launch_lsb,
    input  logic             abort,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [DLY_W-1:0] dly_raw,
    output logic             busy,
    output logic [DLY_W-1:0] dly_eff,
    output logic             ser_clk,
    output logic             ser_data
);
    localparam int unsigned SLOT_W = PH_W + 1;
    localparam int unsigned CNT_W  = $clog2(NBITS);

    typedef struct packed {
        logic             busy;
        logic [PH_W-1:0]  ph;
        logic [CNT_W-1:0] cnt;
        logic [NBITS-1:0] sh;
        logic             lsb;
        logic             hold;
    } ser_t;

    ser_t st_d, st_q;
    logic [PH_W-1:0] slot_m1, half;
    logic            cur_bit;

    always_comb begin
        slot_m1 = PH_W'((SLOT_W'(4) << div_sel) - SLOT_W'(1));
        half    = PH_W'(SLOT_W'(2) << div_sel);
        dly_eff = (PH_W'(dly_raw) > (half - PH_W'(1))) ? DLY_W'(half - PH_W'(1)) : dly_raw;
        cur_bit = st_q.lsb ? st_q.sh[0] : st_q.sh[NBITS-1];
    end

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (abort) begin
                st_d.busy = 1'b0;
            end else if (st_q.ph == slot_m1) begin
                st_d.hold = cur_bit;
                st_d.sh   = st_q.lsb ? (st_q.sh >> 1) : (st_q.sh << 1);
                st_d.ph   = '0;
                if (st_q.cnt == CNT_W'(NBITS - 1)) st_d.busy = 1'b0;
                else                               st_d.cnt  = st_q.cnt + CNT_W'(1);
            end else begin
                st_d.ph = st_q.ph + PH_W'(1);
            end
        end else if (launch) begin
            st_d.busy = 1'b1;
            st_d.ph   = '0;
            st_d.cnt  = '0;
            st_d.sh   = launch_vec;
            st_d.lsb  = launch_lsb;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign ser_clk  = st_q.busy && (st_q.ph >= half);
    assign ser_data = (st_q.busy && (st_q.ph >= PH_W'(dly_eff))) ? cur_bit : st_q.hold;
endmodule

// File: rtl/sled_shift_engine.sv
module sled_shift_engine #(
    parameter int unsigned NBITS = 17,
    parameter int unsigned DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] pin_vec,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [NBITS-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [31:0]      rd_data,
    output logic             ser_clk,
    output logic             ser_data
);
    import sled_pkg::*;

    localparam int unsigned PH_W  = 2 + (2 ** DIV_W) - 1;
    localparam int unsigned DLY_W = PH_W - 1;

    logic [DIV_W-1:0] div_sel;
    logic [DLY_W-1:0] dly_raw, dly_eff;
    logic             lsb_first, pwm_en, busy;
    logic [NBITS-1:0] last_vec, launch_vec;
    logic             launch, launch_lsb, abort;

    sled_cfg #(.NBITS(NBITS), .DIV_W(DIV_W), .DLY_W(DLY_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pin_vec(pin_vec), .busy(busy), .div_sel(div_sel), .dly_raw(dly_raw),
        .lsb_first(lsb_first), .pwm_en(pwm_en), .last_vec(last_vec), .launch(launch),
        .launch_vec(launch_vec), .launch_lsb(launch_lsb), .abort(abort)
    );

    sled_serializer #(.NBITS(NBITS), .DIV_W(DIV_W), .PH_W(PH_W), .DLY_W(DLY_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .launch(launch), .launch_vec(launch_vec),
        .launch_lsb(launch_lsb), .abort(abort), .div_sel(div_sel), .dly_raw(dly_raw),
        .busy(busy), .dly_eff(dly_eff), .ser_clk(ser_clk), .ser_data(ser_data)
    );

    always_comb begin
        rd_data = '0;
        case (sled_sel_e'(rd_sel))
            SEL_DATA: begin
                rd_data[NBITS-1:0] = last_vec;
                rd_data[RD_W-1]    = busy;
            end
            SEL_DIV:  rd_data[DIV_W-1:0] = div_sel;
            SEL_DLY:  rd_data[DLY_W-1:0] = dly_raw;
            SEL_MODE: rd_data[1:0]       = {pwm_en, lsb_first};
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/sled_chk.sv
module sled_chk #(
    parameter int unsigned NBITS = 17,
    parameter int unsigned DIV_W = 2,
    parameter int unsigned DLY_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             ser_clk,
    input logic             ser_data,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [NBITS-1:0] pin_vec,
    input logic [NBITS-1:0] last_vec,
    input logic             pwm_en,
    input logic [DLY_W-1:0] dly_eff,
    input logic [DIV_W-1:0] div_sel
);
    AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ser_clk); // R2

    AST_DLY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        int'(dly_eff) <= ((2 << div_sel) - 1)); // R3

    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ser_clk && $past(ser_clk)) |-> $stable(ser_data)); // R3

    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && wr_sel == 2'd0) |=> busy); // R5

    AST_BUSY_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && wr_sel == 2'd0) |=> $stable(last_vec)); // R6

    AST_BUSY_NO_PWM_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pwm_en) |=> !pwm_en); // R6

    AST_PWM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en && !busy && !wr_en && pin_vec == last_vec) |=> !busy); // R7
endmodule

bind sled_shift_engine sled_chk #(.NBITS(NBITS), .DIV_W(DIV_W), .DLY_W(DLY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ser_clk(ser_clk), .ser_data(ser_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .pin_vec(pin_vec), .last_vec(last_vec),
    .pwm_en(pwm_en), .dly_eff(dly_eff), .div_sel(div_sel)
);

// File: tb/sled_shift_engine_tb.sv
module sled_shift_engine_tb;
    localparam int NB = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] pin_vec = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [NB-1:0] wr_data = '0;
    logic [1:0]    rd_sel = '0;
    logic [31:0]   rd_data;
    logic          ser_clk, ser_data;

    int nchk = 0;
    int nerr = 0;
    logic hold_exp = 1'b0;

    always #5 clk = ~clk;

    sled_shift_engine u_dut (
        .clk(clk), .rst_n(rst_n), .pin_vec(pin_vec), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .ser_clk(ser_clk), .ser_data(ser_data)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = NB'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [1:0] sel, input int exp, input string tag);
        rd_sel = sel;
        #1;
        check(rd_data == 32'(exp), tag, int'(rd_data), exp);
        rd_sel = 2'd0;
    endtask

    function automatic logic fbit(input logic [NB-1:0] v, input logic lsb, input int b);
        return lsb ? v[b] : v[NB-1-b];
    endfunction

    // Called at the negedge right after the launching edge (phase 0 of slot 0).
    task automatic check_frame(input logic [NB-1:0] v, input logic lsb, input int div,
                               input int dly, input string tag);
        int n = 4 << div;
        int de = (dly > n/2 - 1) ? n/2 - 1 : dly;
        int bad = 0;
        for (int k = 0; k < NB * n; k++) begin
            int ph = k % n;
            int b = k / n;
            logic ec = (ph >= n/2);
            logic ed = (ph >= de) ? fbit(v, lsb, b) : ((b == 0) ? hold_exp : fbit(v, lsb, b - 1));
            if (ser_clk !== ec || ser_data !== ed || rd_data[31] !== 1'b1) begin
                if (bad == 0)
                    $display("FAIL %s cycle %0d actual clk/data/busy=%b%b%b expected=%b%b1",
                             tag, k, ser_clk, ser_data, rd_data[31], ec, ed);
                bad++;
            end
            @(negedge clk);
        end
        if (ser_clk !== 1'b0 || ser_data !== fbit(v, lsb, NB-1) || rd_data[31] !== 1'b0) begin
            if (bad == 0)
                $display("FAIL %s end-of-frame actual clk/data/busy=%b%b%b expected=0%b0",
                         tag, ser_clk, ser_data, rd_data[31], fbit(v, lsb, NB-1));
            bad++;
        end
        hold_exp = fbit(v, lsb, NB-1);
        nchk++;
        if (bad != 0) nerr++;
    endtask

    task automatic wait_idle();
        while (rd_data[31]) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [NB-1:0] a, p, q;
        int it = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ser_clk == 1'b0 && ser_data == 1'b0, "R1 outputs in reset", {ser_clk, ser_data}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_check(2'd0, 0, "R1 data reg after reset");
        rd_check(2'd1, 0, "R1 divider after reset");
        rd_check(2'd2, 0, "R1 delay after reset");
        rd_check(2'd3, 0, "R1 mode after reset");

        // R2 R3 R4 R5 R9: sweep divider, delay (including clamped values), bit order
        for (int div = 0; div < 4; div++) begin
            for (int dly = 0; dly < 16; dly++) begin
                for (int lsb = 0; lsb < 2; lsb++) begin
                    logic [NB-1:0] v = NB'((it * 40503 + 12345) ^ (it << 7));
                    it++;
                    wr(2'd1, div);
                    wr(2'd2, dly);
                    wr(2'd3, lsb);
                    wr(2'd0, int'(v));
                    check_frame(v, lsb[0], div, dly, "R2 R3 R4 R5 R9 sweep frame");
                end
            end
            rd_check(2'd1, div, "R8 divider readback");
            rd_check(2'd2, 15, "R8 delay readback");
        end

        // R5: all-zero direct write still shifts a frame
        wr(2'd1, 0); wr(2'd2, 1); wr(2'd3, 0);
        wr(2'd0, 0);
        check_frame('0, 1'b0, 0, 1, "R5 zero frame");
        rd_check(2'd0, 0, "R8 data readback zero");

        // R6: writes ignored while busy
        a = 17'h15A3C;
        wr(2'd0, int'(a));
        wr(2'd0, 17'h0F0F0);
        wr(2'd1, 3);
        wr(2'd2, 0);
        wr(2'd3, 3);
        wait_idle();
        hold_exp = a[0];
        rd_check(2'd0, int'(a), "R6 data write ignored while busy");
        rd_check(2'd1, 0, "R6 divider write ignored while busy");
        rd_check(2'd2, 1, "R6 delay write ignored while busy");
        rd_check(2'd3, 0, "R6 mode set ignored while busy");
        repeat (10) @(negedge clk);
        check(rd_data[31] == 1'b0 && ser_clk == 1'b0, "R6 no extra frame", int'(rd_data[31]), 0);
        check(ser_data == hold_exp, "R9 idle holds last bit", ser_data, hold_exp);

        // R7: PWM mode, zero pins with zero history stays idle
        wr(2'd0, 0);
        wait_idle();
        hold_exp = 1'b0;
        wr(2'd1, 1); wr(2'd2, 2);
        wr(2'd3, 2);
        rd_check(2'd3, 2, "R8 mode readback pwm");
        repeat (30) @(negedge clk);
        check(rd_data[31] == 1'b0, "R7 zero pins no shift", int'(rd_data[31]), 0);

        // R7: pin change launches frame; change during frame launches a follow-on frame
        p = 17'h1C071;
        q = 17'h00A55;
        pin_vec = p;
        @(negedge clk);
        fork
            check_frame(p, 1'b0, 1, 2, "R7 pwm frame");
            begin
                repeat (40) @(negedge clk);
                pin_vec = q;
            end
        join
        @(negedge clk);
        check_frame(q, 1'b0, 1, 2, "R7 pwm follow-on frame");
        repeat (20) @(negedge clk);
        check(rd_data[31] == 1'b0, "R7 unchanged pins stay idle", int'(rd_data[31]), 0);
        rd_check(2'd0, int'(q), "R8 last frame readback");

        // R6 abort by clearing PWM mode; R9 hold after abort
        pin_vec = p;
        @(negedge clk);
        check(rd_data[31] == 1'b1, "R7 launch on change", int'(rd_data[31]), 1);
        wr(2'd3, 0);
        check(rd_data[31] == 1'b0 && ser_clk == 1'b0, "R6 abort stops frame",
              {rd_data[31], ser_clk}, 0);
        check(ser_data == hold_exp, "R9 hold after abort", ser_data, hold_exp);
        rd_check(2'd3, 0, "R6 mode after abort");

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule